// File: doc/BRIEF.md
# Per-Channel Status Register Block with Edge Filtering

This block keeps the status registers for four identical output channels of a programmable supply. Each channel has two register groups. The questionable group collects fault-type conditions such as overvoltage, overtemperature and loss of regulation. The operation group collects operating-mode conditions such as constant-voltage, constant-current and output-off. Live condition bits come from sensing logic. They are synchronised and then passed through per-bit rising-edge and falling-edge filters. A transition that passes its filter is latched into a sticky event register.

Each group ANDs its event register with an enable mask and reduces the result to one channel summary. All four questionable summaries are ORed into a single questionable summary pin, and all four operation summaries into a single operation summary pin. A service-request stage elsewhere uses these two pins. A host programs the filters and masks through a simple register port. The same port reads back the condition and event registers, and reading an event register also clears it.

Top module: `chstat_top`

## Requirements
- R1: After reset, every rising-edge filter reads back as its group's defined-bit mask, every falling-edge filter and enable mask reads zero, every event register reads zero, and both summary outputs are low.
- R2: The register address is {channel[1:0], group, select[2:0]}. Group 0 is questionable and group 1 is operation. Select 0 is condition, 1 is rising filter, 2 is falling filter, 3 is event and 4 is enable. Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`. Selects 5 to 7 read zero.
- R3: The defined bits are 0x5417 in a questionable group (bits 0, 1, 2, 4, 10, 12, 14) and 0x007F in an operation group (bits 0 to 6). Undefined bits read zero and ignore writes.
- R4: The condition register is read-only. It shows the live input after a two-flop synchroniser, and writes to it have no effect.
- R5: A 0-to-1 change of a synchronised condition bit sets the matching event bit when the bit's rising filter is set, and only then.
- R6: A 1-to-0 change of a synchronised condition bit sets the matching event bit when the bit's falling filter is set, and only then.
- R7: Event bits stay set, even after the condition goes away, until the host reads that event register. That read returns the value and clears the register on the same edge.
- R8: An input change is latched on the third rising edge after it is applied. If that edge coincides with a read of the same event register, the new bit survives the clear, and the read returns the value from before that edge.
- R9: A channel summary is the OR of (event AND enable). `ques_sum_o` is the OR of the four questionable summaries, and `oper_sum_o` is the OR of the four operation summaries.
- R10: A write to a filter or enable register takes effect on the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ques_cond_i | input | 64 | Questionable condition inputs, channel c at bits [16c+15:16c] |
| oper_cond_i | input | 64 | Operation condition inputs, channel c at bits [16c+15:16c] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears an addressed event register) |
| reg_addr_i | input | 6 | Register address {channel, group, select} |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| ques_sum_o | output | 1 | OR of all enabled questionable events |
| oper_sum_o | output | 1 | OR of all enabled operation events |

## Verification
The hardest case to reach is an edge-filtered transition landing on the same clock edge as the host's clearing read of that event register. The stimulus first latches one event bit. It then changes a second condition bit and asserts the read strobe exactly two edges later, so the read coincides with the third edge of the synchroniser-plus-detector path. The bench expects the old bit in the read data and only the new bit in the register afterwards. Filter behaviour is swept over every channel and group with several pairs of condition patterns and filter settings. The expected event word is computed arithmetically from the old pattern, the new pattern and the two filters.

// File: rtl/chstat_pkg.sv
// Package: shared register-select encoding and defined-bit masks for the
// channel status block. Assumes 16-bit registers.
package chstat_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_COND = 3'd0,
        SEL_RISE = 3'd1,
        SEL_FALL = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_ENA  = 3'd4
    } sel_e;

    localparam logic [15:0] QUES_BITS = 16'h5417;
    localparam logic [15:0] OPER_BITS = 16'h007F;

endpackage

// File: rtl/chstat_sync.sv
// Two-flop synchroniser for a bus of independent level signals.
// Assumes each bit is a slowly changing level; there is no bus coherency.
module chstat_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/chstat_group.sv
// One status register group: synchronised condition, rising and falling
// edge filters, sticky event register, enable mask and summary bit.
// Assumes the parent decodes the address and raises wr_en_i or clr_i only
// for this group. VALID marks the defined bit positions.
module chstat_group
    import chstat_pkg::*;
#(
    parameter int          W     = 16,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cond_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     wr_data_i,
    input  logic             clr_i,
    output logic [W-1:0]     rd_val_o,
    output logic             sum_o
);
    logic [W-1:0] cond_s;
    logic [W-1:0] cond_q;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic [W-1:0] ena_q;
    logic [W-1:0] evt_q;
    logic [W-1:0] up_w;
    logic [W-1:0] dn_w;
    logic [W-1:0] set_w;

    chstat_sync #(.W(W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cond_i),
        .q_o   (cond_s)
    );

    // Previous synchronised condition, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_s;
    end

    // Edge detection and filtering against the programmed filters.
    always_comb begin
        up_w  = cond_s & ~cond_q;
        dn_w  = ~cond_s & cond_q;
        set_w = ((up_w & rise_q) | (dn_w & fall_q)) & VALID;
    end

    // Rising-edge filter register, all defined bits on at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rise_q <= VALID;
        else if (wr_en_i && sel_i == SEL_RISE) rise_q <= wr_data_i & VALID;
    end

    // Falling-edge filter register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            fall_q <= '0;
        else if (wr_en_i && sel_i == SEL_FALL) fall_q <= wr_data_i & VALID;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ena_q <= '0;
        else if (wr_en_i && sel_i == SEL_ENA) ena_q <= wr_data_i & VALID;
    end

    // Sticky event register; a new set outranks a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (clr_i ? '0 : evt_q) | set_w;
    end

    // Read-back selection for the parent's read mux.
    always_comb begin
        case (sel_i)
            SEL_COND: rd_val_o = cond_s & VALID;
            SEL_RISE: rd_val_o = rise_q;
            SEL_FALL: rd_val_o = fall_q;
            SEL_EVT:  rd_val_o = evt_q;
            SEL_ENA:  rd_val_o = ena_q;
            default:  rd_val_o = '0;
        endcase
    end

    assign sum_o = |(evt_q & ena_q);

    // R5 R8
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_s & ~cond_q & rise_q & VALID) != '0) |=>
        ((evt_q & $past(cond_s & ~cond_q & rise_q & VALID))
            == $past(cond_s & ~cond_q & rise_q & VALID)));

    // R6
    fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cond_s & cond_q & fall_q & VALID) != '0) |=>
        ((evt_q & $past(~cond_s & cond_q & fall_q & VALID))
            == $past(~cond_s & cond_q & fall_q & VALID)));

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    // R10
    rise_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i == SEL_RISE) |=> (rise_q == $past(wr_data_i & VALID)));
endmodule

// File: rtl/chstat_top.sv
// Status register block for NUM_CH channels, each with a questionable and an
// operation group. Decodes the host register port, clears event registers
// on read, and ORs per-channel summaries into two outputs.
// Assumes NUM_CH is a power of two of at least 2.
module chstat_top
    import chstat_pkg::*;
#(
    parameter int              NUM_CH    = 4,
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] Q_VALID = QUES_BITS,
    parameter logic [DATA_W-1:0] O_VALID = OPER_BITS,
    localparam int             CH_W      = $clog2(NUM_CH),
    localparam int             ADDR_W    = CH_W + 1 + SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*DATA_W-1:0] ques_cond_i,
    input  logic [NUM_CH*DATA_W-1:0] oper_cond_i,
    input  logic                     reg_wr_i,
    input  logic                     reg_rd_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     ques_sum_o,
    output logic                     oper_sum_o
);
    localparam int NGRP  = NUM_CH * 2;
    localparam int IDX_W = CH_W + 1;

    logic [SEL_W-1:0] sel_w;
    logic [IDX_W-1:0] idx_w;
    logic [DATA_W-1:0] grp_rd [NGRP];
    logic [NUM_CH-1:0] q_sum_vec;
    logic [NUM_CH-1:0] o_sum_vec;
    logic [DATA_W-1:0] rd_mux_w;

    assign sel_w = reg_addr_i[SEL_W-1:0];
    assign idx_w = reg_addr_i[ADDR_W-1:SEL_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar g = 0; g < 2; g++) begin : g_grp
            localparam int GI = c * 2 + g;
            logic hit_w;
            logic sum_w;
            assign hit_w = (idx_w == IDX_W'(GI));

            chstat_group #(
                .W     (DATA_W),
                .VALID ((g == 0) ? Q_VALID : O_VALID)
            ) grp_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cond_i    ((g == 0) ? ques_cond_i[c*DATA_W +: DATA_W]
                                     : oper_cond_i[c*DATA_W +: DATA_W]),
                .wr_en_i   (reg_wr_i && hit_w),
                .sel_i     (sel_w),
                .wr_data_i (reg_wdata_i),
                .clr_i     (reg_rd_i && hit_w && sel_w == SEL_EVT),
                .rd_val_o  (grp_rd[GI]),
                .sum_o     (sum_w)
            );

            if (g == 0) begin : g_q
                assign q_sum_vec[c] = sum_w;
            end else begin : g_o
                assign o_sum_vec[c] = sum_w;
            end
        end
    end

    // Select the addressed group's read value.
    always_comb rd_mux_w = grp_rd[idx_w];

    // Registered read data, zero when no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_rdata_o <= '0;
        else if (reg_rd_i) reg_rdata_o <= rd_mux_w;
        else               reg_rdata_o <= '0;
    end

    assign ques_sum_o = |q_sum_vec;
    assign oper_sum_o = |o_sum_vec;

    // R2
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && sel_w > SEL_W'(4)) |=> (reg_rdata_o == '0));
endmodule

// File: tb/chstat_top_tb_top.sv
module chstat_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] qc = '0;
    logic [63:0] oc = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        qsum;
    logic        osum;
    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] d;

    always #4 clk = ~clk;

    chstat_top dut_i (
        .clk(clk), .rst_n(rst_n), .ques_cond_i(qc), .oper_cond_i(oc),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .ques_sum_o(qsum), .oper_sum_o(osum)
    );

    function automatic logic [5:0] mk(int c, int g, int s);
        return {2'(c), 1'(g), 3'(s)};
    endfunction

    function automatic logic [15:0] vm(int g);
        return (g == 0) ? 16'h5417 : 16'h007F;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(int c, int g, int s, logic [15:0] v);
        @(negedge clk);
        wr = 1'b1; addr = mk(c, g, s); wdata = v;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(int c, int g, int s, output logic [15:0] v);
        @(negedge clk);
        rd = 1'b1; addr = mk(c, g, s);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic scond(int c, int g, logic [15:0] v);
        @(negedge clk);
        if (g == 0) qc[c*16 +: 16] = v;
        else        oc[c*16 +: 16] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] xs [4] = '{16'h0F0F, 16'hFFFF, 16'h1234, 16'h0000};
        logic [15:0] ys [4] = '{16'h3C3C, 16'h0000, 16'hEDCB, 16'hFFFF};
        logic [15:0] as [4] = '{16'hFFFF, 16'h0000, 16'h5555, 16'hFFFF};
        logic [15:0] bs [4] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'hFFFF};
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state of every group
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                rreg(c, g, 1, d); chk("R1 rise", d, vm(g));
                rreg(c, g, 2, d); chk("R1 fall", d, 16'h0);
                rreg(c, g, 4, d); chk("R1 ena", d, 16'h0);
                rreg(c, g, 3, d); chk("R1 evt", d, 16'h0);
            end
        end
        chk("R1 sums", {14'h0, qsum, osum}, 16'h0);

        // R3 R10 R2: masking, immediate effect, unused selects
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                wreg(c, g, 1, 16'hFFFF); rreg(c, g, 1, d); chk("R3 R10 rise", d, vm(g));
                wreg(c, g, 2, 16'hA5A5); rreg(c, g, 2, d); chk("R3 R10 fall", d, 16'hA5A5 & vm(g));
                wreg(c, g, 4, 16'hFFFF); rreg(c, g, 4, d); chk("R3 ena", d, vm(g));
                wreg(c, g, 2, 16'h0000);
                wreg(c, g, 4, 16'h0000);
                for (int s = 5; s < 8; s++) begin
                    rreg(c, g, s, d); chk("R2 unused sel", d, 16'h0);
                end
            end
        end

        // R4 R2: condition read-back per channel/group, writes ignored
        for (int c = 0; c < 4; c++)
            for (int g = 0; g < 2; g++)
                scond(c, g, 16'h1357 ^ 16'((c * 2 + g) * 16'h1111));
        idle(3);
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                logic [15:0] v;
                v = (16'h1357 ^ 16'((c * 2 + g) * 16'h1111)) & vm(g);
                rreg(c, g, 0, d); chk("R4 R2 cond", d, v);
                wreg(c, g, 0, ~v);
                rreg(c, g, 0, d); chk("R4 cond write ignored", d, v);
                scond(c, g, 16'h0);
            end
        end
        idle(4);
        for (int c = 0; c < 4; c++)
            for (int g = 0; g < 2; g++)
                rreg(c, g, 3, d);

        // R5 R6: filter sweep with arithmetic expectation
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [15:0] x, y, e;
                    x = xs[p] ^ 16'(c * 16'h0101);
                    y = ys[p] ^ 16'(g * 16'h8001);
                    wreg(c, g, 1, as[p]);
                    wreg(c, g, 2, bs[p]);
                    scond(c, g, x); idle(4);
                    rreg(c, g, 3, d);
                    scond(c, g, y); idle(4);
                    e = ((y & ~x & as[p]) | (x & ~y & bs[p])) & vm(g);
                    rreg(c, g, 3, d); chk("R5 R6 filtered event", d, e);
                    scond(c, g, 16'h0); idle(4);
                    rreg(c, g, 3, d);
                end
                wreg(c, g, 1, 16'hFFFF);
                wreg(c, g, 2, 16'h0000);
                rreg(c, g, 3, d); chk("R7 cleared by read", d, 16'h0);
            end
        end

        // R7: event persists after condition goes away
        scond(0, 0, 16'h0001); idle(4);
        scond(0, 0, 16'h0000); idle(10);
        rreg(0, 0, 3, d); chk("R7 sticky", d, 16'h0001);
        rreg(0, 0, 3, d); chk("R7 read clears", d, 16'h0000);

        // R8: transition on the clearing read edge survives
        scond(1, 1, 16'h0001); idle(4);
        @(negedge clk) oc[16 +: 16] = 16'h0003;
        @(posedge clk); @(negedge clk); @(posedge clk);
        @(negedge clk) begin rd = 1'b1; addr = mk(1, 1, 3); end
        @(posedge clk);
        @(negedge clk) rd = 1'b0;
        chk("R8 read returns old", rdata, 16'h0001);
        rreg(1, 1, 3, d); chk("R8 new bit survives", d, 16'h0002);
        scond(1, 1, 16'h0); idle(4);

        // R9 R10: summary gating and channel OR
        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 2; g++) begin
                scond(c, g, 16'h0004); idle(4);
                @(negedge clk);
                chk("R9 no enable", {14'h0, qsum, osum}, 16'h0);
                wreg(c, g, 4, 16'h0001);
                chk("R9 enable mismatch", {14'h0, qsum, osum}, 16'h0);
                wreg(c, g, 4, 16'h0004);
                chk("R9 R10 summary set", {14'h0, qsum, osum}, (g == 0) ? 16'h2 : 16'h1);
                wreg(c, g, 4, 16'h0000);
                chk("R9 R10 summary off", {14'h0, qsum, osum}, 16'h0);
                wreg(c, g, 4, 16'h0004);
                rreg(c, g, 3, d);
                @(negedge clk);
                chk("R9 cleared summary", {14'h0, qsum, osum}, 16'h0);
                wreg(c, g, 4, 16'h0000);
                scond(c, g, 16'h0);
            end
        end
        idle(4);
        scond(0, 0, 16'h0010); scond(3, 0, 16'h0010); idle(4);
        wreg(0, 0, 4, 16'h0010); wreg(3, 0, 4, 16'h0010);
        wreg(0, 0, 4, 16'h0000);
        chk("R9 other channel holds OR", {14'h0, qsum, osum}, 16'h2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule